// File: doc/BRIEF.md
# Dual-Slope Percent Differential Comparator

This block is the decision stage of a low-impedance bus differential element for one protection zone. Once per processing cycle it receives a set of filtered per-unit current magnitudes, one bit per channel saying whether that circuit currently belongs to the zone, and the magnitude of the vector sum of the in-zone currents. The upstream summer applies the same membership bits when it forms that sum. From the magnitudes the block selects the restraint quantity: the largest magnitude among the in-zone channels. It then places the operating point (restraint, differential) on a biased characteristic made of a low-slope segment, a high-slope segment and a straight transition between two breakpoints, all floored by a minimum pickup. It also compares the differential against an unrestrained high-set level.

All magnitudes and current settings are unsigned fixed-point per-unit values with the same scaling. Slopes are whole percentages. Results are registered on the clock edge that samples a valid strobe and are held until the next strobe. They are exported as a biased pickup flag, an unrestrained operate flag, the restraint value and two region flags, for a downstream saturation detector and directional supervision.

Top module: `bus_diff_comparator`

## Requirements
- R1: The restraint output equals the largest `in_mag` among channels whose `in_zone` bit is 1; a channel with its bit at 0 has no effect on it, however large its magnitude.
- R2: With every `in_zone` bit at 0 the restraint is 0, and the biased pickup then depends only on the minimum-pickup floor.
- R3: When restraint ≤ `cfg_low_bp`, the slope test passes only if 100·diff > `cfg_low_slope`·restraint.
- R4: When restraint > `cfg_high_bp`, the slope test passes only if 100·diff > `cfg_high_slope`·restraint.
- R5: When `cfg_low_bp` < restraint ≤ `cfg_high_bp`, the threshold is the straight line from `cfg_low_slope`·`cfg_low_bp`/100 at the low breakpoint to `cfg_high_slope`·`cfg_high_bp`/100 at the high breakpoint, evaluated exactly without division.
- R6: Biased pickup additionally requires diff > `cfg_min_pickup`, in every region.
- R7: `out_operate` is 1 exactly when diff > `cfg_high_set`, independent of restraint and of the biased result.
- R8: All outputs update on the rising clock edge at which `in_valid` is 1, `out_valid` is 1 for exactly the following cycle, and outputs hold their values while `in_valid` is 0. Reset (synchronous, `rst_n` low) clears every output to 0.
- R9: `out_region_low` is 1 when restraint ≤ `cfg_low_bp`; `out_region_high` (region 2) is 1 when restraint > `cfg_high_bp`; region 1 is the case `out_region_high` = 0.
- R10: All comparisons are strict: an operating point lying exactly on the threshold, on the floor or on the high-set level does not operate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Strobe marking a new set of magnitudes |
| in_mag | input | N_CH*MAG_W | Per-channel magnitudes, channel k at bits [k*MAG_W +: MAG_W] |
| in_zone | input | N_CH | Zone membership bit per channel |
| in_diff | input | MAG_W | Magnitude of the in-zone vector sum |
| cfg_min_pickup | input | MAG_W | Minimum differential for biased pickup |
| cfg_low_bp | input | MAG_W | Low breakpoint on restraint |
| cfg_high_bp | input | MAG_W | High breakpoint on restraint |
| cfg_low_slope | input | PCT_W | Low slope in percent (15..100) |
| cfg_high_slope | input | PCT_W | High slope in percent (50..100) |
| cfg_high_set | input | MAG_W | Unrestrained operate level |
| out_valid | output | 1 | One-cycle flag for fresh results |
| out_restraint | output | MAG_W | Selected restraint |
| out_pickup | output | 1 | Biased characteristic pickup |
| out_operate | output | 1 | Unrestrained operate |
| out_region_low | output | 1 | Restraint at or below the low breakpoint |
| out_region_high | output | 1 | Restraint above the high breakpoint (region 2) |

## Verification
The hardest conditions to reach are operating points that sit exactly on a threshold, above all inside the transition segment, where the line must be evaluated exactly and a random draw almost never lands on it. Directed cases pick the restraint and breakpoints so that the interpolated threshold times the segment width is an integer, then apply a differential one step below, on, and one step above it. Likewise, a disabled channel carrying the largest magnitude is forced in directed cases, so that membership visibly changes the restraint and the pickup. Random trials with a fixed seed then sweep channel membership, magnitudes and settings across all three regions.

// File: rtl/bdiff_pkg.sv
// Package: shared definitions for the dual-slope differential comparator.
// Assumes slopes are expressed in whole percent.
package bdiff_pkg;
    // Scale that turns a percentage slope into a ratio
    localparam int PCT_SCALE = 100;

    // Position of the restraint on the characteristic
    typedef enum logic [1:0] {
        SEG_LOW  = 2'd0,
        SEG_MID  = 2'd1,
        SEG_HIGH = 2'd2
    } seg_e;
endpackage

// File: rtl/restraint_select.sv
// Module: restraint_select
// Picks the largest magnitude among channels flagged as in-zone.
// Assumes magnitudes are unsigned; yields zero when no channel is in zone.
module restraint_select #(
    parameter int N_CH  = 6,
    parameter int MAG_W = 16
) (
    input  logic [N_CH*MAG_W-1:0] mags,
    input  logic [N_CH-1:0]       zone,
    output logic [MAG_W-1:0]      restraint
);
    logic [MAG_W-1:0] gated [N_CH];

    // Zero the magnitude of every channel outside the zone
    for (genvar g = 0; g < N_CH; g++) begin : g_gate
        assign gated[g] = zone[g] ? mags[g*MAG_W +: MAG_W] : '0;
    end

    // Linear scan for the largest gated magnitude
    always_comb begin
        restraint = '0;
        for (int k = 0; k < N_CH; k++) begin
            if (gated[k] > restraint) restraint = gated[k];
        end
    end
endmodule

// File: rtl/slope_compare.sv
// Module: slope_compare
// Tests one operating point against the dual-slope characteristic with
// a linear transition between the breakpoints and a minimum floor.
// Assumes all current quantities share one fixed-point scaling and that
// slopes are percentages; every comparison is exact via cross-multiplying.
module slope_compare
    import bdiff_pkg::*;
#(
    parameter int MAG_W = 16,
    parameter int PCT_W = 7
) (
    input  logic [MAG_W-1:0] restraint,
    input  logic [MAG_W-1:0] diff,
    input  logic [MAG_W-1:0] min_pickup,
    input  logic [MAG_W-1:0] low_bp,
    input  logic [MAG_W-1:0] high_bp,
    input  logic [PCT_W-1:0] low_slope,
    input  logic [PCT_W-1:0] high_slope,
    output seg_e             segment,
    output logic             pickup
);
    localparam int PROD_W = 2*MAG_W + PCT_W + 3;

    logic [PROD_W-1:0] d_w, r_w, lb_w, hb_w, ls_w, hs_w;
    logic [PROD_W-1:0] d_scaled, low_rhs, high_rhs, mid_lhs, mid_rhs;
    logic              slope_ok, floor_ok;

    // Widen all operands so products cannot overflow
    assign d_w  = PROD_W'(diff);
    assign r_w  = PROD_W'(restraint);
    assign lb_w = PROD_W'(low_bp);
    assign hb_w = PROD_W'(high_bp);
    assign ls_w = PROD_W'(low_slope);
    assign hs_w = PROD_W'(high_slope);

    // Classify the restraint against the two breakpoints
    always_comb begin
        if (restraint <= low_bp)      segment = SEG_LOW;
        else if (restraint > high_bp) segment = SEG_HIGH;
        else                          segment = SEG_MID;
    end

    // Products for each segment, threshold scaled by 100 (and width in the middle)
    always_comb begin
        d_scaled = d_w * PROD_W'(PCT_SCALE);
        low_rhs  = ls_w * r_w;
        high_rhs = hs_w * r_w;
        mid_lhs  = d_scaled * (hb_w - lb_w);
        mid_rhs  = ls_w * lb_w * (hb_w - r_w) + hs_w * hb_w * (r_w - lb_w);
    end

    // Strict comparison in the active segment plus the pickup floor
    always_comb begin
        unique case (segment)
            SEG_LOW:  slope_ok = d_scaled > low_rhs;
            SEG_HIGH: slope_ok = d_scaled > high_rhs;
            default:  slope_ok = mid_lhs > mid_rhs;
        endcase
        floor_ok = diff > min_pickup;
        pickup   = slope_ok && floor_ok;
    end
endmodule

// File: rtl/bus_diff_comparator.sv
// Module: bus_diff_comparator
// Zone-level decision stage: selects restraint from in-zone magnitudes,
// evaluates the biased characteristic and the unrestrained high set, and
// registers all results on the valid strobe.
// Assumes in_diff already excludes channels whose zone bit is clear.
module bus_diff_comparator
    import bdiff_pkg::*;
#(
    parameter int N_CH  = 6,
    parameter int MAG_W = 16,
    parameter int PCT_W = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [N_CH*MAG_W-1:0] in_mag,
    input  logic [N_CH-1:0]       in_zone,
    input  logic [MAG_W-1:0]      in_diff,
    input  logic [MAG_W-1:0]      cfg_min_pickup,
    input  logic [MAG_W-1:0]      cfg_low_bp,
    input  logic [MAG_W-1:0]      cfg_high_bp,
    input  logic [PCT_W-1:0]      cfg_low_slope,
    input  logic [PCT_W-1:0]      cfg_high_slope,
    input  logic [MAG_W-1:0]      cfg_high_set,
    output logic                  out_valid,
    output logic [MAG_W-1:0]      out_restraint,
    output logic                  out_pickup,
    output logic                  out_operate,
    output logic                  out_region_low,
    output logic                  out_region_high
);
    logic [MAG_W-1:0] restraint_c;
    seg_e             segment_c;
    logic             pickup_c;
    logic             operate_c;

    restraint_select #(
        .N_CH  (N_CH),
        .MAG_W (MAG_W)
    ) i_restraint (
        .mags      (in_mag),
        .zone      (in_zone),
        .restraint (restraint_c)
    );

    slope_compare #(
        .MAG_W (MAG_W),
        .PCT_W (PCT_W)
    ) i_slope (
        .restraint  (restraint_c),
        .diff       (in_diff),
        .min_pickup (cfg_min_pickup),
        .low_bp     (cfg_low_bp),
        .high_bp    (cfg_high_bp),
        .low_slope  (cfg_low_slope),
        .high_slope (cfg_high_slope),
        .segment    (segment_c),
        .pickup     (pickup_c)
    );

    // Unrestrained element ignores restraint entirely
    assign operate_c = in_diff > cfg_high_set;

    // Valid flag follows the strobe by one clock
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Capture results on the strobe, hold them otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_restraint   <= '0;
            out_pickup      <= 1'b0;
            out_operate     <= 1'b0;
            out_region_low  <= 1'b0;
            out_region_high <= 1'b0;
        end else if (in_valid) begin
            out_restraint   <= restraint_c;
            out_pickup      <= pickup_c;
            out_operate     <= operate_c;
            out_region_low  <= (segment_c == SEG_LOW);
            out_region_high <= (segment_c == SEG_HIGH);
        end
    end

    // Each in-zone channel is bounded by the selected restraint
    for (genvar g = 0; g < N_CH; g++) begin : g_chk
        AST_REST_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_zone[g]) |-> (in_mag[g*MAG_W +: MAG_W] <= restraint_c)); // R1
    end

    AST_REST_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_zone == '0)) |-> (restraint_c == '0)); // R2

    AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R8

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R8

    AST_HOLD_PICKUP: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_pickup) && $stable(out_operate) && $stable(out_restraint))); // R8

    AST_REGION_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (cfg_low_bp <= cfg_high_bp)) |=> !(out_region_low && out_region_high)); // R9
endmodule

// File: tb/test_bus_diff_comparator.sv
module test_bus_diff_comparator;
    localparam int N  = 6;
    localparam int MW = 16;
    localparam int PW = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [N*MW-1:0] in_mag = '0;
    logic [N-1:0]  in_zone = '0;
    logic [MW-1:0] in_diff = '0;
    logic [MW-1:0] cfg_min_pickup = 16'd20;
    logic [MW-1:0] cfg_low_bp = 16'd300;
    logic [MW-1:0] cfg_high_bp = 16'd900;
    logic [PW-1:0] cfg_low_slope = 7'd30;
    logic [PW-1:0] cfg_high_slope = 7'd70;
    logic [MW-1:0] cfg_high_set = 16'd5000;
    logic          out_valid, out_pickup, out_operate, out_region_low, out_region_high;
    logic [MW-1:0] out_restraint;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    bus_diff_comparator #(.N_CH(N), .MAG_W(MW), .PCT_W(PW)) i_bus_diff_comparator (
        .clk, .rst_n, .in_valid, .in_mag, .in_zone, .in_diff,
        .cfg_min_pickup, .cfg_low_bp, .cfg_high_bp, .cfg_low_slope,
        .cfg_high_slope, .cfg_high_set, .out_valid, .out_restraint,
        .out_pickup, .out_operate, .out_region_low, .out_region_high
    );

    task automatic check(string req, longint act, longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint model_rest();
        longint r = 0;
        for (int k = 0; k < N; k++)
            if (in_zone[k] && longint'(in_mag[k*MW +: MW]) > r) r = longint'(in_mag[k*MW +: MW]);
        return r;
    endfunction

    // Threshold scaled by 100*(hb-lb) in the transition segment, else by 100
    function automatic bit model_pickup(longint r, longint d);
        longint lb = cfg_low_bp, hb = cfg_high_bp, ls = cfg_low_slope, hs = cfg_high_slope;
        bit ok;
        if (r <= lb)     ok = (100*d > ls*r);
        else if (r > hb) ok = (100*d > hs*r);
        else             ok = (100*d*(hb-lb) > ls*lb*(hb-r) + hs*hb*(r-lb));
        return ok && (d > longint'(cfg_min_pickup));
    endfunction

    // Apply one strobe at a falling edge, check at the next falling edge, then check hold
    task automatic run_one(string tag);
        longint r, d;
        bit p, o, lo, hi;
        in_valid = 1'b1;
        r  = model_rest();
        d  = in_diff;
        p  = model_pickup(r, d);
        o  = d > longint'(cfg_high_set);
        lo = r <= longint'(cfg_low_bp);
        hi = r > longint'(cfg_high_bp);
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " R8 valid"}, out_valid, 1);
        check({tag, " R1 restraint"}, out_restraint, r);
        check({tag, " R3/R4/R5/R6 pickup"}, out_pickup, p);
        check({tag, " R7 operate"}, out_operate, o);
        check({tag, " R9 low"}, out_region_low, lo);
        check({tag, " R9 high"}, out_region_high, hi);
        in_diff = ~in_diff;
        in_zone = ~in_zone;
        @(negedge clk);
        check({tag, " R8 pulse"}, out_valid, 0);
        check({tag, " R8 hold pickup"}, out_pickup, p);
        check({tag, " R8 hold restraint"}, out_restraint, r);
    endtask

    task automatic set_mags(int a, int b, int c, int d, int e, int f);
        in_mag = {MW'(f), MW'(e), MW'(d), MW'(c), MW'(b), MW'(a)};
    endtask

    initial begin
        int seed = 0;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check("R8 reset valid", out_valid, 0);
        check("R8 reset pickup", out_pickup, 0);
        check("R8 reset restraint", out_restraint, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: excluded channel holds the largest magnitude
        set_mags(100, 250, 4000, 50, 0, 10); in_zone = 6'b111011; in_diff = 16'd60;
        run_one("d_r1_excl");
        in_zone = 6'b111111; in_diff = 16'd60;
        run_one("d_r1_incl");
        // R2: nothing in zone, floor decides
        in_zone = '0; in_diff = 16'd21; run_one("d_r2_above");
        in_zone = '0; in_diff = 16'd20; run_one("d_r2_floor_R10");
        // R3/R10: r=200, ls=30 -> 100d > 6000; d=60 no, 61 yes
        set_mags(200, 0, 0, 0, 0, 0); in_zone = 6'b000001;
        in_diff = 16'd60; run_one("d_r3_equal_R10");
        in_diff = 16'd61; run_one("d_r3_above");
        // R9: restraint exactly at low breakpoint stays low
        set_mags(300, 0, 0, 0, 0, 0); in_diff = 16'd91; run_one("d_r9_at_lb");
        // R5: lb=300 hb=900 ls=30 hs=70, r=600: rhs=30*300*300+70*900*300=21600000, den 600 -> d=360 exact
        set_mags(600, 0, 0, 0, 0, 0);
        in_diff = 16'd360; run_one("d_r5_on_line_R10");
        in_diff = 16'd361; run_one("d_r5_above");
        in_diff = 16'd359; run_one("d_r5_below");
        // R4: r=1000 hs=70 -> 100d > 70000; d=700 no, 701 yes
        set_mags(1000, 0, 0, 0, 0, 0);
        in_diff = 16'd700; run_one("d_r4_equal_R10");
        in_diff = 16'd701; run_one("d_r4_above");
        // R6: floor above slope line in low segment
        set_mags(10, 0, 0, 0, 0, 0); cfg_min_pickup = 16'd100;
        in_diff = 16'd100; run_one("d_r6_floor");
        in_diff = 16'd101; run_one("d_r6_over");
        cfg_min_pickup = 16'd20;
        // R7: high set regardless of huge restraint
        set_mags(60000, 0, 0, 0, 0, 0);
        in_diff = 16'd5000; run_one("d_r7_equal_R10");
        in_diff = 16'd5001; run_one("d_r7_above");

        // Random sweep across all segments
        for (int t = 0; t < 400; t++) begin
            for (int k = 0; k < N; k++) in_mag[k*MW +: MW] = MW'($urandom_range(0, 3000));
            in_zone        = N'($urandom);
            cfg_low_bp     = MW'($urandom_range(100, 1000));
            cfg_high_bp    = cfg_low_bp + MW'($urandom_range(1, 1500));
            cfg_low_slope  = PW'($urandom_range(15, 100));
            cfg_high_slope = PW'($urandom_range(50, 100));
            cfg_min_pickup = MW'($urandom_range(0, 200));
            cfg_high_set   = MW'($urandom_range(500, 4000));
            in_diff        = MW'($urandom_range(0, 4000));
            run_one($sformatf("rnd%0d", t));
            seed++;
        end
        done = 1;
    end

    initial begin
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=done");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule